// File: doc/BRIEF.md
# Paged Cartridge Dump Sequencer

This block copies the full ROM image out of a plug-in game cartridge by driving the cartridge's address bus, its bidirectional data bus and its active-low output-enable and write strobes directly. After a start pulse it first reads the two pages that are always visible at the bottom of the address space. It then brings in each remaining page in turn: it writes the page number into the cartridge's bank register, and reads the 16 KiB window where that page now appears. Every byte read is offered on a valid/ready byte stream in ascending image order.

The caller supplies the total page count of the image and a flag that picks the paging style. The style used for 128 KiB images has its own bank register address and its own window base. Every read cycle also pulls low the pre-decoded region-select line that matches the current address. The page size is a parameter (16 KiB by default). Setup and strobe durations are parameters in clock cycles, and any value below 2 is raised to 2. The address comes from a two-stage counter with a clear input and an increment input, and a fixed window base is ORed onto the counter value.

Top module: `cart_dump_seq`

## Requirements
- R1: After reset, and until the first start, cart_oe_n and cart_we_n are 1, data_oe is 0, region_sel_n is 3'b111, byte_valid is 0 and done is 0.
- R2: A read cycle holds the address for max(SETUP_CYC,2) cycles with both strobes high. It then holds cart_oe_n low for max(STROBE_CYC,2) cycles with the address unchanged, and captures the bus on the last of those cycles.
- R3: Stream bytes 0 to 2*P-1 (P = 2**PAGE_LOG2 bytes per page) come from addresses 0 to 2*P-1 in ascending order, and no register write happens before all of them have been accepted.
- R4: The number of paged pages is page_total-2, or 0 when page_total is 2 or less. The page numbers written are 2, 3, 4 and so on, in ascending order, one per page.
- R5: A register write drives address 16'hFFFF when mode_128k=1 and 16'hFFFE when mode_128k=0, with the page number on cart_data. It pulls cart_oe_n and cart_we_n low together for max(STROBE_CYC,2) cycles and then releases both.
- R6: After page k is written, stream byte k*P+j is read from address 16'h8000+j when mode_128k=1 and from 16'h4000+j when mode_128k=0.
- R7: During every read cycle exactly one bit of region_sel_n is 0: bit 0 for addresses 0x0000-0x7FFF, bit 1 for 0x8000-0xBFFF and bit 2 for 0xC000-0xFFFF. Outside read cycles all three bits are 1.
- R8: data_oe is 1, and cart_data is driven, only from the start of a register write's address setup until one cycle after its strobes are released. At all other times the bus is high-impedance.
- R9: While byte_valid is 1 and byte_ready is 0, byte_valid stays 1 and byte_data does not change. No byte is dropped or repeated.
- R10: done rises in the cycle after the last byte's handshake, once max(page_total,2)*P bytes have been transferred. It stays 1 with the bus idle until the next start, and a start accepted from this state begins a new run.
- R11: A start pulse while a run is in progress, including one in the same cycle as the last byte's handshake, has no effect on the stream, the writes or the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a dump when idle or done |
| page_total | input | PAGE_W | Total pages in the image |
| mode_128k | input | 1 | 1: bank register 0xFFFF, window 0x8000; 0: 0xFFFE, 0x4000 |
| cart_addr | output | 16 | Cartridge address bus |
| cart_data | inout | 8 | Cartridge data bus |
| data_oe | output | 1 | 1 while the block drives cart_data |
| cart_oe_n | output | 1 | Active-low output enable |
| cart_we_n | output | 1 | Active-low write strobe |
| region_sel_n | output | 3 | Active-low pre-decoded region selects |
| byte_data | output | 8 | Stream byte |
| byte_valid | output | 1 | Stream byte valid |
| byte_ready | input | 1 | Stream consumer ready |
| done | output | 1 | Dump complete |

## Verification
A start pulse can land in the same cycle as the handshake that accepts the final byte, the one edge where the sequencer leaves its busy state. The bench provokes this by raising start exactly at that handshake, and it also pulses start with a different page count in the middle of a run. It judges the outcome at the ports: done must then hold with no further stream bytes or strobes, and the byte sequence and bank writes must match the image computed from the first request.

// File: rtl/cdump_pkg.sv
package cdump_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_STROBE,
        ST_RD_OFFER,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_RELEASE,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        RGN_LOW  = 2'd0,
        RGN_MID  = 2'd1,
        RGN_HIGH = 2'd2
    } region_t;

    localparam int NUM_REGIONS = 3;

    // Bank register and window base for each paging style.
    localparam logic [15:0] BANKREG_128K = 16'hFFFF;
    localparam logic [15:0] BANKREG_STD  = 16'hFFFE;
    localparam logic [15:0] WINDOW_128K  = 16'h8000;
    localparam logic [15:0] WINDOW_STD   = 16'h4000;

    // Cartridge-side bus controls derived from the sequencer state.
    typedef struct packed {
        logic [15:0] addr;
        logic        oe_n;
        logic        we_n;
        logic        drive;
        logic        rd_active;
    } bus_ctl_t;

    function automatic region_t region_of(input logic [15:0] a);
        case (a[15:14])
            2'b10:   return RGN_MID;
            2'b11:   return RGN_HIGH;
            default: return RGN_LOW;
        endcase
    endfunction

    function automatic int clamp_min2(input int v);
        return (v < 2) ? 2 : v;
    endfunction

endpackage

// File: rtl/cdump_addr_counter.sv
module cdump_addr_counter #(
    parameter int LO_W = 12,
    parameter int HI_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 inc,
    output logic [LO_W+HI_W-1:0] count
);
    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    logic            carry;

    assign carry = inc && (&lo_q);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lo_q <= '0;
        end else if (inc) begin
            lo_q <= lo_q + LO_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hi_q <= '0;
        end else if (carry) begin
            hi_q <= hi_q + HI_W'(1);
        end
    end

    assign count = {hi_q, lo_q};
endmodule

// File: rtl/cdump_phase_timer.sv
module cdump_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/cdump_region_sel.sv
module cdump_region_sel
    import cdump_pkg::*;
(
    input  logic [15:0]            addr,
    input  logic                   active,
    output logic [NUM_REGIONS-1:0] sel_n
);
    region_t rgn;
    assign rgn = region_of(addr);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_sel
        assign sel_n[g] = !(active && (rgn == region_t'(g)));
    end
endmodule

// File: rtl/cart_dump_seq.sv
module cart_dump_seq
    import cdump_pkg::*;
#(
    parameter int PAGE_LOG2  = 14,
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 2,
    parameter int PAGE_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PAGE_W-1:0] page_total,
    input  logic              mode_128k,
    output logic [15:0]       cart_addr,
    inout  wire  [7:0]        cart_data,
    output logic              data_oe,
    output logic              cart_oe_n,
    output logic              cart_we_n,
    output logic [2:0]        region_sel_n,
    output logic [7:0]        byte_data,
    output logic              byte_valid,
    input  logic              byte_ready,
    output logic              done
);
    localparam int SU   = clamp_min2(SETUP_CYC);
    localparam int ST   = clamp_min2(STROBE_CYC);
    localparam int TMAX = (SU > ST) ? SU : ST;
    localparam int TW   = $clog2(TMAX) + 1;
    localparam logic [TW-1:0] SU_L = TW'(SU - 1);
    localparam logic [TW-1:0] ST_L = TW'(ST - 1);
    localparam logic [15:0] LAST_FIRST = 16'((2 << PAGE_LOG2) - 1);
    localparam logic [15:0] LAST_PAGED = 16'((1 << PAGE_LOG2) - 1);

    seq_state_t        st_q, st_d;
    logic [PAGE_W-1:0] left_q;
    logic [PAGE_W-1:0] pg_q;
    logic              paged_q;
    logic              big_q;
    logic [7:0]        byte_q;

    logic              cnt_clr, cnt_inc;
    logic              tmr_load, tmr_exp;
    logic [TW-1:0]     tmr_val;
    logic              begin_run, cap, wr_done;
    logic [15:0]       offset;
    logic [15:0]       seg_base;
    logic              seg_last;
    bus_ctl_t          bus;

    cdump_addr_counter #(.LO_W(12), .HI_W(4)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (offset)
    );

    cdump_phase_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    assign seg_base = paged_q ? (big_q ? WINDOW_128K : WINDOW_STD) : 16'h0000;
    assign seg_last = paged_q ? (offset == LAST_PAGED) : (offset == LAST_FIRST);

    // Bus controls by state.
    always_comb begin
        bus.addr      = seg_base | offset;
        bus.oe_n      = 1'b1;
        bus.we_n      = 1'b1;
        bus.drive     = 1'b0;
        bus.rd_active = 1'b0;
        case (st_q)
            ST_RD_SETUP, ST_RD_OFFER: begin
                bus.rd_active = 1'b1;
            end
            ST_RD_STROBE: begin
                bus.rd_active = 1'b1;
                bus.oe_n      = 1'b0;
            end
            ST_WR_SETUP, ST_WR_RELEASE: begin
                bus.addr  = big_q ? BANKREG_128K : BANKREG_STD;
                bus.drive = 1'b1;
            end
            ST_WR_STROBE: begin
                bus.addr  = big_q ? BANKREG_128K : BANKREG_STD;
                bus.drive = 1'b1;
                bus.oe_n  = 1'b0;
                bus.we_n  = 1'b0;
            end
            default: ;
        endcase
    end

    // Next state and control pulses.
    always_comb begin
        st_d      = st_q;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = SU_L;
        begin_run = 1'b0;
        cap       = 1'b0;
        wr_done   = 1'b0;
        case (st_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    begin_run = 1'b1;
                    cnt_clr   = 1'b1;
                    tmr_load  = 1'b1;
                    st_d      = ST_RD_SETUP;
                end
            end
            ST_RD_SETUP: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = ST_L;
                    st_d     = ST_RD_STROBE;
                end
            end
            ST_RD_STROBE: begin
                if (tmr_exp) begin
                    cap  = 1'b1;
                    st_d = ST_RD_OFFER;
                end
            end
            ST_RD_OFFER: begin
                if (byte_ready) begin
                    if (!seg_last) begin
                        cnt_inc  = 1'b1;
                        tmr_load = 1'b1;
                        st_d     = ST_RD_SETUP;
                    end else if (left_q == '0) begin
                        st_d = ST_DONE;
                    end else begin
                        tmr_load = 1'b1;
                        st_d     = ST_WR_SETUP;
                    end
                end
            end
            ST_WR_SETUP: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = ST_L;
                    st_d     = ST_WR_STROBE;
                end
            end
            ST_WR_STROBE: begin
                if (tmr_exp) begin
                    st_d = ST_WR_RELEASE;
                end
            end
            ST_WR_RELEASE: begin
                wr_done  = 1'b1;
                cnt_clr  = 1'b1;
                tmr_load = 1'b1;
                st_d     = ST_RD_SETUP;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            left_q  <= '0;
            pg_q    <= '0;
            paged_q <= 1'b0;
            big_q   <= 1'b0;
            byte_q  <= '0;
        end else begin
            st_q <= st_d;
            if (begin_run) begin
                big_q   <= mode_128k;
                left_q  <= (page_total > PAGE_W'(2)) ? page_total - PAGE_W'(2) : '0;
                pg_q    <= PAGE_W'(2);
                paged_q <= 1'b0;
            end
            if (cap) begin
                byte_q <= cart_data;
            end
            if (wr_done) begin
                paged_q <= 1'b1;
                left_q  <= left_q - PAGE_W'(1);
                pg_q    <= pg_q + PAGE_W'(1);
            end
        end
    end

    cdump_region_sel u_rsel (
        .addr   (bus.addr),
        .active (bus.rd_active),
        .sel_n  (region_sel_n)
    );

    assign cart_addr  = bus.addr;
    assign cart_oe_n  = bus.oe_n;
    assign cart_we_n  = bus.we_n;
    assign data_oe    = bus.drive;
    assign cart_data  = bus.drive ? 8'(pg_q) : 8'hzz;
    assign byte_data  = byte_q;
    assign byte_valid = (st_q == ST_RD_OFFER);
    assign done       = (st_q == ST_DONE);
endmodule

// File: rtl/cdump_checker.sv
module cdump_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cart_addr,
    input logic        data_oe,
    input logic        cart_oe_n,
    input logic        cart_we_n,
    input logic [2:0]  region_sel_n,
    input logic [7:0]  byte_data,
    input logic        byte_valid,
    input logic        byte_ready,
    input logic        done
);
    // R5: the write strobe only ever falls together with output-enable
    p_we_with_oe_r5: assert property (@(posedge clk) disable iff (rst)
        !cart_we_n |-> !cart_oe_n);

    // R8: the bus is driven during every write strobe and never during a read strobe
    p_drive_in_write_r8: assert property (@(posedge clk) disable iff (rst)
        !cart_we_n |-> data_oe);
    p_float_in_read_r8: assert property (@(posedge clk) disable iff (rst)
        (!cart_oe_n && cart_we_n) |-> !data_oe);

    // R7: at most one select, exactly one during a read strobe, none while driving
    p_sel_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~region_sel_n));
    p_sel_in_read_r7: assert property (@(posedge clk) disable iff (rst)
        (!cart_oe_n && cart_we_n) |-> ($countones(~region_sel_n) == 1));
    p_sel_off_write_r7: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> (region_sel_n == 3'b111));

    // R2: address steady across a strobe, strobe low for at least two cycles
    p_addr_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (!cart_oe_n && !$fell(cart_oe_n)) |-> $stable(cart_addr));
    p_strobe_min_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(cart_oe_n) |=> !cart_oe_n);

    // R9: an offered byte is held until taken
    p_hold_byte_r9: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));

    // R10: once done the bus and the stream are quiet
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!byte_valid && cart_oe_n && cart_we_n && !data_oe));
endmodule

bind cart_dump_seq cdump_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .cart_addr    (cart_addr),
    .data_oe      (data_oe),
    .cart_oe_n    (cart_oe_n),
    .cart_we_n    (cart_we_n),
    .region_sel_n (region_sel_n),
    .byte_data    (byte_data),
    .byte_valid   (byte_valid),
    .byte_ready   (byte_ready),
    .done         (done)
);

// File: tb/tb_cart_dump_seq.sv
module tb_cart_dump_seq;
    localparam int PL    = 4;
    localparam int P     = 1 << PL;
    localparam int SETUP = 2;
    localparam int STRB  = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  page_total = 8'd0;
    logic        mode_128k = 1'b0;
    logic [15:0] cart_addr;
    wire  [7:0]  cart_data;
    logic        data_oe, cart_oe_n, cart_we_n;
    logic [2:0]  region_sel_n;
    logic [7:0]  byte_data;
    logic        byte_valid;
    logic        byte_ready = 1'b0;
    logic        done;

    int tests = 0;
    int fails = 0;
    int n_acc = 0;
    int wr_cnt = 0;
    int bank = 0;
    logic cur_mode = 1'b0;
    logic [7:0] rom_byte;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cart_dump_seq #(.PAGE_LOG2(PL), .SETUP_CYC(SETUP), .STROBE_CYC(STRB), .PAGE_W(8)) dut (
        .clk(clk), .rst(rst), .start(start), .page_total(page_total),
        .mode_128k(mode_128k), .cart_addr(cart_addr), .cart_data(cart_data),
        .data_oe(data_oe), .cart_oe_n(cart_oe_n), .cart_we_n(cart_we_n),
        .region_sel_n(region_sel_n), .byte_data(byte_data),
        .byte_valid(byte_valid), .byte_ready(byte_ready), .done(done)
    );

    function automatic logic [7:0] img(input int idx);
        return 8'(((idx * 29) + (idx >> 3)) ^ 8'h3C);
    endfunction

    // Cartridge model: first two pages fixed, one banked window.
    always_comb begin
        if (int'(cart_addr) < 2 * P) rom_byte = img(int'(cart_addr));
        else rom_byte = img(bank * P + (int'(cart_addr) & (P - 1)));
    end
    assign cart_data = (!cart_oe_n && !data_oe) ? rom_byte : 8'hzz;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_sel(input logic [15:0] a);
        if (!a[15]) return 3'b110;
        if (!a[14]) return 3'b101;
        return 3'b011;
    endfunction

    // Bank register writes and strobe widths.
    bit   prev_we = 1'b1;
    int   oe_low = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!cart_we_n && prev_we) begin
                chk(cart_addr == (cur_mode ? 16'hFFFF : 16'hFFFE), "R5 bank reg addr",
                    int'(cart_addr), cur_mode ? 'hFFFF : 'hFFFE);
                chk(int'(cart_data) == 2 + wr_cnt, "R4 page number", int'(cart_data), 2 + wr_cnt);
                chk(n_acc == (2 + wr_cnt) * P, "R3 write after prior pages", n_acc, (2 + wr_cnt) * P);
                chk(data_oe == 1'b1, "R8 drive during write", int'(data_oe), 1);
                bank = int'(cart_data);
                wr_cnt++;
            end
            if (!cart_oe_n) oe_low++;
            else if (oe_low != 0) begin
                chk(oe_low == STRB, "R2 strobe width", oe_low, STRB);
                oe_low = 0;
            end
            prev_we = cart_we_n;
        end
    end

    task automatic run(input int total, input bit mode, input int kind,
                       input bit busy_start, input bit last_start);
        int exp_bytes;
        int exp_wr;
        int cyc;
        bit r;
        bit held;
        logic [7:0] held_data;
        logic [15:0] ea;
        exp_bytes = ((total > 2) ? total : 2) * P;
        exp_wr = (total > 2) ? total - 2 : 0;
        n_acc = 0; wr_cnt = 0; bank = 0; cyc = 0; held = 0; held_data = '0;
        cur_mode = mode;
        page_total = 8'(total);
        mode_128k = mode;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R10 done clears on start", int'(done), 0);
        while (n_acc < exp_bytes && cyc < 20000) begin
            start = 1'b0;
            if (busy_start && cyc == 37) begin
                start = 1'b1;             // R11: mid-run start with other settings
                page_total = 8'd1;
                mode_128k = ~mode;
            end
            case (kind)
                0: r = 1'b1;
                1: r = (cyc % 3) != 0;
                default: r = (((cyc * 7) >> 2) & 1) == 1;
            endcase
            if (held) begin
                chk(byte_valid && byte_data == held_data, "R9 held byte",
                    int'(byte_data), int'(held_data));
            end
            byte_ready = r;
            held = byte_valid && !r;
            held_data = byte_data;
            if (byte_valid && r) begin
                ea = (n_acc < 2 * P) ? 16'(n_acc)
                     : 16'((mode ? 'h8000 : 'h4000) + (n_acc % P));
                chk(byte_data == img(n_acc), n_acc < 2 * P ? "R3 byte" : "R6 byte",
                    int'(byte_data), int'(img(n_acc)));
                chk(cart_addr == ea, n_acc < 2 * P ? "R3 address" : "R6 address",
                    int'(cart_addr), int'(ea));
                chk(region_sel_n == exp_sel(ea), "R7 select", int'(region_sel_n), int'(exp_sel(ea)));
                chk(data_oe == 1'b0, "R8 bus released on read", int'(data_oe), 0);
                n_acc++;
                if (n_acc == exp_bytes && last_start) start = 1'b1;   // R11 same-cycle start
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        byte_ready = 1'b0;
        chk(cyc < 20000, "R10 run completes", cyc, 20000);
        chk(done == 1'b1, "R10 done after last byte", int'(done), 1);
        chk(wr_cnt == exp_wr, "R4 page write count", wr_cnt, exp_wr);
        for (int i = 0; i < 12; i++) begin
            byte_ready = 1'b1;
            @(negedge clk);
            chk(!byte_valid && done && cart_oe_n && region_sel_n == 3'b111,
                "R11 quiet after done", int'(byte_valid), 0);
        end
        byte_ready = 1'b0;
        chk(wr_cnt == exp_wr, "R11 no extra writes", wr_cnt, exp_wr);
        page_total = 8'd0;
    endtask

    initial begin
        int totals [6] = '{0, 1, 2, 3, 5, 8};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cart_oe_n && cart_we_n, "R1 strobes idle", {cart_oe_n, cart_we_n}, 3);
        chk(data_oe == 1'b0, "R1 bus released", int'(data_oe), 0);
        chk(region_sel_n == 3'b111, "R1 selects idle", int'(region_sel_n), 7);
        chk(!byte_valid && !done, "R1 stream idle", {byte_valid, done}, 0);
        for (int m = 0; m < 2; m++) begin
            for (int t = 0; t < 6; t++) begin
                run(totals[t], m[0], (t + m) % 3, totals[t] == 5, 1'b0);
            end
        end
        run(4, 1'b1, 2, 1'b0, 1'b1);
        run(3, 1'b0, 1, 1'b1, 1'b1);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog R10 actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule